// File: doc/BRIEF.md
# Return Address Stack Controller

This block keeps the return addresses of nested subroutine calls in a small byte-wide RAM region. A 4-bit pointer selects one of sixteen bytes that start at a fixed base address (0x30 by default), so the byte address is always the base plus the pointer. The stack grows toward lower addresses. The pointer always marks the next free byte. Each saved 11-bit address takes two bytes.

On a call strobe, the block writes the low byte of the return address first and the upper three bits second. It then moves the pointer down by two. On a return strobe, it reads both bytes back through a RAM with one cycle of read latency and rebuilds the address. It then moves the pointer up by two. A byte-wide register port lets software read the pointer as a full RAM byte address, or load it with one.

After reset, the restored-address output holds the program reset vector. The program space sits above a space-select bit, so address 0x800 is held as the 11-bit value 0x000. `busy_o` marks the cycles in which a transfer is in flight.

Top module: `ras_ctrl`

## Requirements
- R1: After reset the pointer is 0xF (`sp_rdata_o` reads 0x3F), `pop_addr_o` is 0x000 (the low 11 bits of reset vector 0x800), and `busy_o`, `ram_we_o` and `pop_valid_o` are low.
- R2: Every RAM access uses byte address 0x30 plus a 4-bit offset. Reading the pointer port returns 0x30 plus the pointer.
- R3: A completed push lowers the pointer by two and a completed pop raises it by two, both modulo 16. Wrapping raises no fault.
- R4: In the first cycle after a call is accepted, `ram_we_o` is 1, the address is 0x30+sp and the data is the address bits [7:0]. In the next cycle, `ram_we_o` is 1, the address is 0x30+((sp-1) mod 16) and the data is {5'b0, address bits [10:8]}.
- R5: In the first cycle after a return is accepted, the RAM address is 0x30+((sp+1) mod 16), which holds the high byte. In the next cycle it is 0x30+((sp+2) mod 16), which holds the low byte. Read data is expected one cycle after its address.
- R6: Four cycles after a return is accepted, `pop_valid_o` pulses high for one cycle. In that cycle `pop_addr_o` equals {high byte bits [2:0], low byte}, and it holds that value afterwards.
- R7: `busy_o` is high for exactly 2 cycles per push and 3 cycles per pop. While `busy_o` is high, the call, return and pointer-write inputs have no effect.
- R8: When idle, call takes priority over return, and return takes priority over a pointer write. Only the winning operation takes place.
- R9: An idle pointer write of byte w with no call or return sets the pointer to (w - 0x30) mod 16. The upper nibble of w is ignored.
- R10: `ram_we_o` is high only in the two write cycles of a push. It is never high during a pop or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Push request strobe |
| ret_i | input | 1 | Pop request strobe |
| ret_addr_i | input | 11 | Return address to save |
| pop_addr_o | output | 11 | Restored return address |
| pop_valid_o | output | 1 | One-cycle pulse when pop_addr_o is updated |
| busy_o | output | 1 | Transfer in progress |
| ram_addr_o | output | 8 | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after address |
| ram_we_o | output | 1 | RAM write enable |
| sp_we_i | input | 1 | Pointer register write strobe |
| sp_wdata_i | input | 8 | Pointer write value as a byte address |
| sp_rdata_o | output | 8 | Pointer read value as a byte address |

## Verification
The bench builds the block with its default parameters: an 11-bit address, a 4-bit pointer, 8-bit RAM words and base 0x30. It loads every one of the sixteen pointer values through the register port and runs a push and pop at each. This reaches every wrap of the offset arithmetic at both ends of the window, for both the write and the read offsets. A chain of ten nested calls overruns the eight-entry window, so the oldest entries are overwritten. Separate runs drive strobes into busy cycles and raise several requests at once, to check that inputs are ignored while busy and that the priority order holds.

// File: rtl/rast_pkg.sv
package rast_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_HI,
    ST_POP_LO,
    ST_POP_FIN
  } rast_state_e;
endpackage

// File: rtl/rast_ptr.sv
module rast_ptr #(
  parameter int unsigned SPW      = 4,
  parameter logic [SPW-1:0] SP_RESET = '1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dec_i,
  input  logic           inc_i,
  input  logic           ld_i,
  input  logic [SPW-1:0] ld_val_i,
  output logic [SPW-1:0] sp_o
);
  localparam logic [SPW-1:0] STEP = SPW'(2);

  logic [SPW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_RESET;
    else if (dec_i) sp_q <= sp_q - STEP;
    else if (inc_i) sp_q <= sp_q + STEP;
    else if (ld_i)  sp_q <= ld_val_i;
  end

  assign sp_o = sp_q;

  p_dec_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> sp_q == $past(sp_q) - STEP);
  p_inc_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> sp_q == $past(sp_q) + STEP);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i || inc_i || ld_i) |=> $stable(sp_q));
  p_one_op_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_i, inc_i, ld_i}));
endmodule

// File: rtl/rast_seq.sv
module rast_seq
  import rast_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        call_i,
  input  logic        ret_i,
  input  logic        sp_we_i,
  output rast_state_e state_o,
  output logic        busy_o,
  output logic        push_load_o,
  output logic        sp_dec_o,
  output logic        sp_inc_o,
  output logic        sp_ld_o,
  output logic        hi_cap_o,
  output logic        lo_cap_o,
  output logic        pop_valid_o
);
  rast_state_e state_q, state_d;
  logic        idle, valid_q;

  assign idle = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (call_i)     state_d = ST_PUSH_LO;
        else if (ret_i) state_d = ST_POP_HI;
      end
      ST_PUSH_LO: state_d = ST_PUSH_HI;
      ST_PUSH_HI: state_d = ST_IDLE;
      ST_POP_HI:  state_d = ST_POP_LO;
      ST_POP_LO:  state_d = ST_POP_FIN;
      ST_POP_FIN: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= (state_q == ST_POP_FIN);
    end
  end

  assign state_o     = state_q;
  assign busy_o      = !idle;
  assign push_load_o = idle && call_i;
  assign sp_ld_o     = idle && !call_i && !ret_i && sp_we_i;
  assign sp_dec_o    = (state_q == ST_PUSH_HI);
  assign sp_inc_o    = (state_q == ST_POP_FIN);
  assign hi_cap_o    = (state_q == ST_POP_LO);
  assign lo_cap_o    = (state_q == ST_POP_FIN);
  assign pop_valid_o = valid_q;

  p_call_starts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !busy_o) |=> busy_o);
  p_push_two_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH_LO) |=> (state_q == ST_PUSH_HI));
  p_busy_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_PUSH_HI && state_q != ST_POP_FIN) |=> busy_o);
  p_ret_pops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && ret_i && !call_i) |=> (state_q == ST_POP_HI));
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |=> !pop_valid_o);
endmodule

// File: rtl/rast_mem_if.sv
module rast_mem_if
  import rast_pkg::*;
#(
  parameter int unsigned AW     = 11,
  parameter int unsigned SPW    = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned RAM_AW = 8,
  parameter logic [RAM_AW-1:0] STACK_BASE = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rast_state_e       state_i,
  input  logic [SPW-1:0]    sp_i,
  input  logic [AW-1:0]     data_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  output logic              ram_we_o
);
  localparam int unsigned HI_W = AW - BYTE_W;
  localparam logic [SPW-1:0] ONE = SPW'(1);
  localparam logic [SPW-1:0] TWO = SPW'(2);

  logic [SPW-1:0] off;

  always_comb begin
    unique case (state_i)
      ST_PUSH_HI:            off = sp_i - ONE;
      ST_POP_HI:             off = sp_i + ONE;
      ST_POP_LO, ST_POP_FIN: off = sp_i + TWO;
      default:               off = sp_i;
    endcase
  end

  assign ram_addr_o  = STACK_BASE + RAM_AW'(off);
  assign ram_we_o    = (state_i == ST_PUSH_LO) || (state_i == ST_PUSH_HI);
  assign ram_wdata_o = (state_i == ST_PUSH_HI)
                     ? {{(BYTE_W-HI_W){1'b0}}, data_i[AW-1:BYTE_W]}
                     : data_i[BYTE_W-1:0];

  p_hi_below_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PUSH_LO) |=> ram_we_o &&
      (ram_addr_o[SPW-1:0] == $past(ram_addr_o[SPW-1:0]) - ONE));
  p_lo_above_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_POP_HI) |=> !ram_we_o &&
      (ram_addr_o[SPW-1:0] == $past(ram_addr_o[SPW-1:0]) + ONE));
  p_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RAM_AW'(ram_addr_o - STACK_BASE) < RAM_AW'(1 << SPW)));
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import rast_pkg::*;
#(
  parameter int unsigned AW     = 11,
  parameter int unsigned SPW    = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned RAM_AW = 8,
  parameter logic [RAM_AW-1:0] STACK_BASE = 8'h30,
  parameter logic [AW:0]       RESET_VEC  = 12'h800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [AW-1:0]     ret_addr_i,
  output logic [AW-1:0]     pop_addr_o,
  output logic              pop_valid_o,
  output logic              busy_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  output logic              ram_we_o,
  input  logic              sp_we_i,
  input  logic [RAM_AW-1:0] sp_wdata_i,
  output logic [RAM_AW-1:0] sp_rdata_o
);
  localparam int unsigned     HI_W     = AW - BYTE_W;
  localparam logic [AW-1:0]   RESET_PC = RESET_VEC[AW-1:0];
  localparam logic [SPW-1:0]  SP_RESET = '1;

  rast_state_e     state;
  logic            push_load, sp_dec, sp_inc, sp_ld, hi_cap, lo_cap;
  logic [SPW-1:0]  sp, sp_ld_val;
  logic [AW-1:0]   push_q, pop_q;
  logic [HI_W-1:0] hi_q;

  rast_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .sp_we_i     (sp_we_i),
    .state_o     (state),
    .busy_o      (busy_o),
    .push_load_o (push_load),
    .sp_dec_o    (sp_dec),
    .sp_inc_o    (sp_inc),
    .sp_ld_o     (sp_ld),
    .hi_cap_o    (hi_cap),
    .lo_cap_o    (lo_cap),
    .pop_valid_o (pop_valid_o)
  );

  assign sp_ld_val = SPW'(sp_wdata_i - STACK_BASE);

  rast_ptr #(.SPW(SPW), .SP_RESET(SP_RESET)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_i    (sp_dec),
    .inc_i    (sp_inc),
    .ld_i     (sp_ld),
    .ld_val_i (sp_ld_val),
    .sp_o     (sp)
  );

  rast_mem_if #(
    .AW(AW), .SPW(SPW), .BYTE_W(BYTE_W), .RAM_AW(RAM_AW), .STACK_BASE(STACK_BASE)
  ) u_mem_if (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .sp_i        (sp),
    .data_i      (push_q),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_we_o    (ram_we_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q <= '0;
      hi_q   <= '0;
      pop_q  <= RESET_PC;
    end else begin
      if (push_load) push_q <= ret_addr_i;
      if (hi_cap)    hi_q   <= ram_rdata_i[HI_W-1:0];
      if (lo_cap)    pop_q  <= {hi_q, ram_rdata_i};
    end
  end

  assign pop_addr_o = pop_q;
  assign sp_rdata_o = STACK_BASE + RAM_AW'(sp);

  p_pop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_valid_o && !lo_cap) |=> $stable(pop_addr_o));
  p_push_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_load |=> ram_we_o && (ram_wdata_o == $past(ret_addr_i[BYTE_W-1:0])));
endmodule

// File: tb/ras_ctrl_tb.sv
`timescale 1ns/1ps
module ras_ctrl_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        call_i = 1'b0, ret_i = 1'b0, sp_we_i = 1'b0;
  logic [10:0] ret_addr_i = '0;
  logic [7:0]  sp_wdata_i = '0;
  logic [10:0] pop_addr_o;
  logic        pop_valid_o, busy_o, ram_we_o;
  logic [7:0]  ram_addr_o, ram_wdata_o, ram_rdata_i, sp_rdata_o;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [3:0]  exp_sp;
  int          n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  ras_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
    .ret_addr_i(ret_addr_i), .pop_addr_o(pop_addr_o), .pop_valid_o(pop_valid_o),
    .busy_o(busy_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .ram_rdata_i(ram_rdata_i), .ram_we_o(ram_we_o), .sp_we_i(sp_we_i),
    .sp_wdata_i(sp_wdata_i), .sp_rdata_o(sp_rdata_o)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
    ram_rdata_i <= mem[ram_addr_o];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] loc(input logic [3:0] o);
    return 8'h30 + {4'h0, o};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic set_sp(input logic [7:0] w);
    sp_we_i = 1'b1; sp_wdata_i = w;
    @(negedge clk_i);
    sp_we_i = 1'b0;
    exp_sp = w[3:0];
    chk(sp_rdata_o == loc(exp_sp), "R9", "pointer load", sp_rdata_o, loc(exp_sp));
  endtask

  // noise: inject strobes during busy cycles; extra: also raise ret and sp_we at start
  task automatic do_push(input logic [10:0] a, input bit noise, input bit extra);
    call_i = 1'b1; ret_addr_i = a;
    if (extra) begin ret_i = 1'b1; sp_we_i = 1'b1; sp_wdata_i = 8'h3A; end
    @(negedge clk_i);
    call_i = 1'b0; ret_i = 1'b0; sp_we_i = 1'b0; ret_addr_i = ~a;
    chk(busy_o, "R7", "busy push c1", busy_o, 1);
    chk(ram_we_o, "R4", "we lo", ram_we_o, 1);
    chk(ram_addr_o == loc(exp_sp), "R4", "addr lo", ram_addr_o, loc(exp_sp));
    chk(ram_wdata_o == a[7:0], "R4", "data lo", ram_wdata_o, a[7:0]);
    exp_mem[loc(exp_sp)] = a[7:0];
    if (noise) begin ret_i = 1'b1; sp_we_i = 1'b1; sp_wdata_i = 8'h35; end
    @(negedge clk_i);
    ret_i = 1'b0; sp_we_i = 1'b0;
    chk(busy_o, "R7", "busy push c2", busy_o, 1);
    chk(ram_we_o, "R4", "we hi", ram_we_o, 1);
    chk(ram_addr_o == loc(exp_sp - 4'd1), "R4", "addr hi", ram_addr_o, loc(exp_sp - 4'd1));
    chk(ram_wdata_o == {5'b0, a[10:8]}, "R4", "data hi", ram_wdata_o, {5'b0, a[10:8]});
    exp_mem[loc(exp_sp - 4'd1)] = {5'b0, a[10:8]};
    if (noise) begin call_i = 1'b1; ret_addr_i = 11'h555; end
    @(negedge clk_i);
    call_i = 1'b0;
    exp_sp = exp_sp - 4'd2;
    chk(!busy_o, "R7", "busy end push", busy_o, 0);
    chk(!ram_we_o, "R10", "we idle", ram_we_o, 0);
    chk(sp_rdata_o == loc(exp_sp), "R3", "sp after push", sp_rdata_o, loc(exp_sp));
    if (noise || extra) begin
      @(negedge clk_i);
      chk(!busy_o && !ram_we_o, "R7", "no op from ignored strobes", busy_o, 0);
      chk(sp_rdata_o == loc(exp_sp), "R8", "sp unchanged", sp_rdata_o, loc(exp_sp));
    end
  endtask

  task automatic do_pop(input bit extra);
    logic [10:0] e;
    e = {exp_mem[loc(exp_sp + 4'd1)][2:0], exp_mem[loc(exp_sp + 4'd2)]};
    ret_i = 1'b1;
    if (extra) begin sp_we_i = 1'b1; sp_wdata_i = 8'h31; end
    @(negedge clk_i);
    ret_i = 1'b0; sp_we_i = 1'b0;
    chk(busy_o, "R7", "busy pop c1", busy_o, 1);
    chk(!ram_we_o, "R10", "we in pop", ram_we_o, 0);
    chk(ram_addr_o == loc(exp_sp + 4'd1), "R5", "addr hi read", ram_addr_o, loc(exp_sp + 4'd1));
    @(negedge clk_i);
    chk(!ram_we_o, "R10", "we in pop", ram_we_o, 0);
    chk(ram_addr_o == loc(exp_sp + 4'd2), "R5", "addr lo read", ram_addr_o, loc(exp_sp + 4'd2));
    @(negedge clk_i);
    chk(busy_o && !pop_valid_o, "R7", "busy pop c3", busy_o, 1);
    @(negedge clk_i);
    exp_sp = exp_sp + 4'd2;
    chk(pop_valid_o, "R6", "pop valid", pop_valid_o, 1);
    chk(pop_addr_o == e, "R6", "pop addr", pop_addr_o, e);
    chk(!busy_o, "R7", "busy end pop", busy_o, 0);
    chk(sp_rdata_o == loc(exp_sp), "R3", "sp after pop", sp_rdata_o, loc(exp_sp));
    @(negedge clk_i);
    chk(!pop_valid_o && pop_addr_o == e, "R6", "pulse and hold", pop_valid_o, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [10:0] a;
    exp_sp = 4'hF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sp_rdata_o == 8'h3F, "R1", "reset sp", sp_rdata_o, 8'h3F);
    chk(pop_addr_o == 11'h000, "R1", "reset vector", pop_addr_o, 0);
    chk(!busy_o && !ram_we_o && !pop_valid_o, "R1", "reset idle", busy_o, 0);

    // sweep of all pointer values, R2 wrap at both ends
    for (int s = 0; s < 16; s++) begin
      set_sp({4'(s) ^ 4'hA, 4'(s)});
      a = 11'((s * 173 + 91) & 11'h7FF);
      do_push(a, 1'b0, 1'b0);
      do_push(~a, 1'b0, 1'b0);
      do_pop(1'b0);
      do_pop(1'b0);
    end

    // deep nest past window size: overwrite and wrap
    set_sp(8'h3F);
    for (int k = 0; k < 10; k++) do_push(11'((k * 311 + 7) & 11'h7FF), 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) do_pop(1'b0);

    // strobes during busy are ignored (R7), priority when idle (R8)
    do_push(11'h6C3, 1'b1, 1'b0);
    do_push(11'h1A5, 1'b0, 1'b1);
    do_pop(1'b1);
    do_pop(1'b0);

    summary();
  end
endmodule